// File: doc/BRIEF.md
# Equalizer Adaptation Score Selector

During link adaptation the receiver steps through a list of candidate equalizer settings and measures the eye for each one. This block turns each measurement into a single score and keeps track of the best candidate seen so far. Each candidate arrives as a stream beat carrying a setting index, a horizontal eye opening (HEO) and a vertical eye opening (VEO). When the beat marked last has been scored, the block pulses `done` and presents the index and score of the winner.

There are four ways to compute the score. Three are simple modes chosen by a 2-bit code: HEO alone, VEO alone, or the smaller of HEO and a scaled VEO. The fourth is a weighted sum with programmable offsets, switched on by its own enable bit. There are two sets of mode and enable inputs, one for the continuous-time equalizer sweep and one for the decision-feedback sweep. A per-beat select picks which set applies. The weight and the two offsets are shared by both sweep types.

Scoring takes two register stages. The stream input is always ready, so one candidate can be accepted on every clock. A `start` pulse clears the running best before a new sweep. The pulse must come at least one cycle after the previous sweep's `done`, and before that sweep's first candidate.

Top module: `fom_select`

## Requirements
- R1: With the configurable formula disabled and mode code 1 (binary 01) selected, a candidate's score equals its HEO.
- R2: With the configurable formula disabled and mode code 2 (binary 10), the score equals the raw VEO.
- R3: With mode code 3 (binary 11), the score is min(HEO, S), where S = (VEO × veo_scale) >> 6, saturated to 2^EYE_W − 1. A scale of 64 is unity.
- R4: Mode code 0 with the configurable formula disabled is scored exactly like code 3, and it sets `config_error`. That flag stays set until reset, across `start` pulses. Mode code 0 with the formula enabled does not set the flag.
- R5: With the selected enable bit high, the score is (HEO − b)·a + (VEO − c)·(256 − a) as a signed value. Here a, b and c are 8-bit unsigned, and the mode code is ignored.
- R6: `sweep_sel` = 0 applies `ctle_mode`/`ctle_cfg_en`, and `sweep_sel` = 1 applies `dfe_mode`/`dfe_cfg_en`. The set that is not selected has no effect on the score. Both sets use the same a, b and c.
- R7: The reported best is the candidate with the largest score in the sweep. On a tie, the earliest candidate wins.
- R8: `done` is high for exactly one cycle, two clock cycles after the cycle in which the last candidate is presented. `best_idx` and `best_score` are valid while `done` is high and hold their values afterwards.
- R9: A `start` pulse discards the previous sweep's best, so the next result depends only on that next sweep's candidates.
- R10: `in_ready` is always high, and candidates presented on consecutive cycles are all scored.
- R11: After reset, `done`, `config_error`, `best_idx` and `best_score` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clears the running best before a sweep |
| sweep_sel | input | 1 | 0: continuous-time sweep settings, 1: decision-feedback sweep settings |
| ctle_mode | input | 2 | Simple mode code for the continuous-time sweep |
| dfe_mode | input | 2 | Simple mode code for the decision-feedback sweep |
| ctle_cfg_en | input | 1 | Enables the weighted formula for the continuous-time sweep |
| dfe_cfg_en | input | 1 | Enables the weighted formula for the decision-feedback sweep |
| fac_a | input | 8 | Weight a in units of 1/256 |
| ofs_b | input | 8 | HEO offset b |
| ofs_c | input | 8 | VEO offset c |
| veo_scale | input | 8 | VEO scale for the minimum mode, 64 = unity |
| in_valid | input | 1 | Candidate beat valid |
| in_ready | output | 1 | Always high |
| in_last | input | 1 | Marks the final candidate of a sweep |
| in_idx | input | IDX_W | Candidate setting index |
| in_heo | input | EYE_W | Horizontal eye opening |
| in_veo | input | EYE_W | Vertical eye opening |
| done | output | 1 | One-cycle pulse when the sweep result is ready |
| best_idx | output | IDX_W | Index of the winning candidate |
| best_score | output | EYE_W' + 12 (EYE_W' = max(EYE_W, 8)) | Signed score of the winning candidate |
| config_error | output | 1 | Sticky flag: invalid mode code was used |

## Verification
Some properties are checked by assertions on every cycle:
- the minimum-mode score never exceeds its HEO;
- the error flag never falls;
- within a sweep the held best score never decreases, and the winning index changes only when the score strictly rises, which forbids a later candidate from winning a tie;
- `done` follows an accepted last beat by exactly two cycles and is only raised when a best exists.

Other behaviour can only be shown by the bench's scenarios:
- the exact arithmetic of each scoring mode, including saturation and negative weighted scores;
- that the deselected sweep settings are truly ignored;
- that a `start` pulse isolates one sweep from the next.

// File: rtl/fom_pkg.sv
package fom_pkg;

    localparam int FACT_W   = 8;
    localparam int FACT_ONE = 256;

    typedef enum logic [1:0] {
        FOM_INVALID = 2'd0,
        FOM_HEO     = 2'd1,
        FOM_VEO     = 2'd2,
        FOM_BOTH    = 2'd3
    } fom_mode_e;

    typedef enum logic {
        SWEEP_CTLE = 1'b0,
        SWEEP_DFE  = 1'b1
    } sweep_e;

    function automatic int max_int(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

    // The invalid code falls back to the minimum-of-both definition.
    function automatic fom_mode_e resolve_mode(input logic [1:0] raw);
        return (raw == 2'd0) ? FOM_BOTH : fom_mode_e'(raw);
    endfunction

endpackage

// File: rtl/fom_calc.sv
module fom_calc
    import fom_pkg::*;
#(
    parameter int EYE_W     = 6,
    parameter int IDX_W     = 4,
    parameter int VEO_SHIFT = 6,
    parameter int DW        = 8,
    parameter int PROD_W    = DW + 11
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fire,
    input  logic                     last,
    input  logic [IDX_W-1:0]         idx,
    input  logic [EYE_W-1:0]         heo,
    input  logic [EYE_W-1:0]         veo,
    input  logic                     sweep_sel,
    input  logic [1:0]               ctle_mode,
    input  logic [1:0]               dfe_mode,
    input  logic                     ctle_cfg_en,
    input  logic                     dfe_cfg_en,
    input  logic [FACT_W-1:0]        fac_a,
    input  logic [FACT_W-1:0]        ofs_b,
    input  logic [FACT_W-1:0]        ofs_c,
    input  logic [FACT_W-1:0]        veo_scale,
    output logic                     s1_valid,
    output logic                     s1_last,
    output logic [IDX_W-1:0]         s1_idx,
    output logic                     s1_use_cfg,
    output logic [EYE_W-1:0]         s1_simple,
    output logic signed [PROD_W-1:0] s1_prod_h,
    output logic signed [PROD_W-1:0] s1_prod_v,
    output logic                     config_error
);

    localparam int VP_W = EYE_W + FACT_W;
    localparam logic [VP_W-1:0] EYE_MAX = VP_W'({EYE_W{1'b1}});

    logic [1:0]               raw_mode;
    logic                     cfg_on;
    fom_mode_e                eff_mode;
    logic                     bad_cfg;
    logic [VP_W-1:0]          vprod;
    logic [VP_W-1:0]          vshift;
    logic [EYE_W-1:0]         vsat;
    logic [EYE_W-1:0]         simple;
    logic signed [DW:0]       dh;
    logic signed [DW:0]       dv;
    logic signed [PROD_W-1:0] dh_x;
    logic signed [PROD_W-1:0] dv_x;
    logic signed [PROD_W-1:0] wa_x;
    logic signed [PROD_W-1:0] wna_x;
    fom_mode_e                s1_mode;
    logic [EYE_W-1:0]         s1_heo;

    // Pick the settings set for this beat's sweep type.
    always_comb begin
        if (sweep_e'(sweep_sel) == SWEEP_DFE) begin
            raw_mode = dfe_mode;
            cfg_on   = dfe_cfg_en;
        end else begin
            raw_mode = ctle_mode;
            cfg_on   = ctle_cfg_en;
        end
        eff_mode = resolve_mode(raw_mode);
        bad_cfg  = !cfg_on && (raw_mode == 2'd0);
    end

    // Simple modes: scaled and saturated VEO, then the selection.
    always_comb begin
        vprod  = VP_W'(veo) * VP_W'(veo_scale);
        vshift = vprod >> VEO_SHIFT;
        vsat   = (vshift > EYE_MAX) ? EYE_MAX[EYE_W-1:0] : vshift[EYE_W-1:0];
        unique case (eff_mode)
            FOM_HEO: simple = heo;
            FOM_VEO: simple = veo;
            default: simple = (heo < vsat) ? heo : vsat;
        endcase
    end

    // Weighted formula: offsets removed, then the two weighted products.
    always_comb begin
        dh    = $signed({1'b0, DW'(heo)}) - $signed({1'b0, DW'(ofs_b)});
        dv    = $signed({1'b0, DW'(veo)}) - $signed({1'b0, DW'(ofs_c)});
        dh_x  = PROD_W'(dh);
        dv_x  = PROD_W'(dv);
        wa_x  = $signed(PROD_W'(fac_a));
        wna_x = $signed(PROD_W'(FACT_ONE - int'(fac_a)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid     <= 1'b0;
            s1_last      <= 1'b0;
            s1_idx       <= '0;
            s1_use_cfg   <= 1'b0;
            s1_simple    <= '0;
            s1_prod_h    <= '0;
            s1_prod_v    <= '0;
            s1_mode      <= FOM_BOTH;
            s1_heo       <= '0;
            config_error <= 1'b0;
        end else begin
            s1_valid <= fire;
            if (fire) begin
                s1_last    <= last;
                s1_idx     <= idx;
                s1_use_cfg <= cfg_on;
                s1_simple  <= simple;
                s1_prod_h  <= dh_x * wa_x;
                s1_prod_v  <= dv_x * wna_x;
                s1_mode    <= eff_mode;
                s1_heo     <= heo;
                if (bad_cfg) config_error <= 1'b1;
            end
        end
    end

    // R3: the minimum-of-both score can never exceed the candidate's HEO.
    assert_both_le_heo_R3: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && !s1_use_cfg && s1_mode == FOM_BOTH) |-> (s1_simple <= s1_heo));

    // R4: the error flag is sticky until reset.
    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        $past(config_error) |-> config_error);

endmodule

// File: rtl/fom_track.sv
module fom_track
    import fom_pkg::*;
#(
    parameter int EYE_W   = 6,
    parameter int IDX_W   = 4,
    parameter int PROD_W  = 19,
    parameter int SCORE_W = PROD_W + 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      s1_valid,
    input  logic                      s1_last,
    input  logic [IDX_W-1:0]          s1_idx,
    input  logic                      s1_use_cfg,
    input  logic [EYE_W-1:0]          s1_simple,
    input  logic signed [PROD_W-1:0]  s1_prod_h,
    input  logic signed [PROD_W-1:0]  s1_prod_v,
    output logic                      done,
    output logic                      have_best,
    output logic [IDX_W-1:0]          best_idx,
    output logic signed [SCORE_W-1:0] best_score
);

    logic signed [SCORE_W-1:0] score;
    logic                      better;

    always_comb begin
        if (s1_use_cfg)
            score = SCORE_W'(s1_prod_h) + SCORE_W'(s1_prod_v);
        else
            score = $signed(SCORE_W'(s1_simple));
        // Strict compare keeps the earliest candidate on a tie.
        better = !have_best || (score > best_score);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done       <= 1'b0;
            have_best  <= 1'b0;
            best_idx   <= '0;
            best_score <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                have_best <= 1'b0;
            end else if (s1_valid) begin
                if (better) begin
                    best_idx   <= s1_idx;
                    best_score <= score;
                end
                have_best <= 1'b1;
                done      <= s1_last;
            end
        end
    end

    // R7: within a sweep the held best never decreases.
    assert_best_monotonic_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(have_best) && have_best && !$past(start)) |-> (best_score >= $past(best_score)));

    // R7: a new winner needs a strictly higher score, so a tie never replaces it.
    assert_tie_keeps_first_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(have_best) && !$past(start) && !$stable(best_idx)) |-> (best_score > $past(best_score)));

    // R8: a result is only announced when a best exists.
    assert_done_has_best_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> have_best);

endmodule

// File: rtl/fom_select.sv
module fom_select
    import fom_pkg::*;
#(
    parameter int EYE_W     = 6,
    parameter int IDX_W     = 4,
    parameter int VEO_SHIFT = 6,
    localparam int DW       = max_int(EYE_W, FACT_W),
    localparam int PROD_W   = DW + 11,
    localparam int SCORE_W  = PROD_W + 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      sweep_sel,
    input  logic [1:0]                ctle_mode,
    input  logic [1:0]                dfe_mode,
    input  logic                      ctle_cfg_en,
    input  logic                      dfe_cfg_en,
    input  logic [7:0]                fac_a,
    input  logic [7:0]                ofs_b,
    input  logic [7:0]                ofs_c,
    input  logic [7:0]                veo_scale,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic                      in_last,
    input  logic [IDX_W-1:0]          in_idx,
    input  logic [EYE_W-1:0]          in_heo,
    input  logic [EYE_W-1:0]          in_veo,
    output logic                      done,
    output logic [IDX_W-1:0]          best_idx,
    output logic signed [SCORE_W-1:0] best_score,
    output logic                      config_error
);

    logic                     fire;
    logic                     s1_valid;
    logic                     s1_last;
    logic [IDX_W-1:0]         s1_idx;
    logic                     s1_use_cfg;
    logic [EYE_W-1:0]         s1_simple;
    logic signed [PROD_W-1:0] s1_prod_h;
    logic signed [PROD_W-1:0] s1_prod_v;
    logic                     have_best;

    assign in_ready = 1'b1;
    assign fire     = in_valid && in_ready;

    fom_calc #(
        .EYE_W(EYE_W), .IDX_W(IDX_W), .VEO_SHIFT(VEO_SHIFT), .DW(DW), .PROD_W(PROD_W)
    ) u_calc (
        .clk(clk), .rst(rst), .fire(fire), .last(in_last), .idx(in_idx),
        .heo(in_heo), .veo(in_veo), .sweep_sel(sweep_sel),
        .ctle_mode(ctle_mode), .dfe_mode(dfe_mode),
        .ctle_cfg_en(ctle_cfg_en), .dfe_cfg_en(dfe_cfg_en),
        .fac_a(fac_a), .ofs_b(ofs_b), .ofs_c(ofs_c), .veo_scale(veo_scale),
        .s1_valid(s1_valid), .s1_last(s1_last), .s1_idx(s1_idx),
        .s1_use_cfg(s1_use_cfg), .s1_simple(s1_simple),
        .s1_prod_h(s1_prod_h), .s1_prod_v(s1_prod_v),
        .config_error(config_error)
    );

    fom_track #(
        .EYE_W(EYE_W), .IDX_W(IDX_W), .PROD_W(PROD_W), .SCORE_W(SCORE_W)
    ) u_track (
        .clk(clk), .rst(rst), .start(start),
        .s1_valid(s1_valid), .s1_last(s1_last), .s1_idx(s1_idx),
        .s1_use_cfg(s1_use_cfg), .s1_simple(s1_simple),
        .s1_prod_h(s1_prod_h), .s1_prod_v(s1_prod_v),
        .done(done), .have_best(have_best),
        .best_idx(best_idx), .best_score(best_score)
    );

    // R8: done follows an accepted last beat by exactly two cycles.
    assert_done_latency_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(fire && in_last, 2));

endmodule

// File: tb/tb_fom_select.sv
module tb_fom_select;
    localparam int EYE_W   = 6;
    localparam int IDX_W   = 4;
    localparam int SCORE_W = 8 + 12;
    localparam int EMAX    = (1 << EYE_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic sweep_sel = 1'b0;
    logic [1:0] ctle_mode = 2'd3;
    logic [1:0] dfe_mode = 2'd3;
    logic ctle_cfg_en = 1'b0;
    logic dfe_cfg_en = 1'b0;
    logic [7:0] fac_a = 8'd0;
    logic [7:0] ofs_b = 8'd0;
    logic [7:0] ofs_c = 8'd0;
    logic [7:0] veo_scale = 8'd64;
    logic in_valid = 1'b0;
    logic in_ready;
    logic in_last = 1'b0;
    logic [IDX_W-1:0] in_idx = '0;
    logic [EYE_W-1:0] in_heo = '0;
    logic [EYE_W-1:0] in_veo = '0;
    logic done;
    logic [IDX_W-1:0] best_idx;
    logic signed [SCORE_W-1:0] best_score;
    logic config_error;

    int checks = 0;
    int failures = 0;
    int h_arr[16];
    int v_arr[16];
    logic [31:0] rng = 32'h1234_5678;

    always #4 clk = ~clk;

    fom_select dut (
        .clk(clk), .rst(rst), .start(start), .sweep_sel(sweep_sel),
        .ctle_mode(ctle_mode), .dfe_mode(dfe_mode),
        .ctle_cfg_en(ctle_cfg_en), .dfe_cfg_en(dfe_cfg_en),
        .fac_a(fac_a), .ofs_b(ofs_b), .ofs_c(ofs_c), .veo_scale(veo_scale),
        .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
        .in_idx(in_idx), .in_heo(in_heo), .in_veo(in_veo),
        .done(done), .best_idx(best_idx), .best_score(best_score),
        .config_error(config_error)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd();
        rng = rng * 32'd1103515245 + 32'd12345;
        return int'(rng[23:16]) & EMAX;
    endfunction

    // Score model written from the requirements.
    function automatic int model(input int h, input int v);
        int m;
        int en;
        int s;
        m  = sweep_sel ? int'(dfe_mode) : int'(ctle_mode);
        en = sweep_sel ? int'(dfe_cfg_en) : int'(ctle_cfg_en);
        if (en != 0)
            return (h - int'(ofs_b)) * int'(fac_a) + (v - int'(ofs_c)) * (256 - int'(fac_a));
        if (m == 0) m = 3;
        if (m == 1) return h;
        if (m == 2) return v;
        s = (v * int'(veo_scale)) >> 6;
        if (s > EMAX) s = EMAX;
        return (h < s) ? h : s;
    endfunction

    // Runs one sweep of n back-to-back candidates from h_arr/v_arr and checks the result.
    task automatic run_sweep(input int n, input string req);
        int bi;
        int bs;
        int sc;
        bi = 0;
        bs = 0;
        for (int i = 0; i < n; i++) begin
            sc = model(h_arr[i], v_arr[i]);
            if (i == 0 || sc > bs) begin
                bs = sc;
                bi = i;
            end
        end
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_idx   = IDX_W'(i);
            in_heo   = EYE_W'(h_arr[i]);
            in_veo   = EYE_W'(v_arr[i]);
            in_last  = (i == n - 1);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        chk(done == 1'b0, "R8 done early", int'(done), 0);
        @(negedge clk);
        chk(done == 1'b1, "R8 done pulse", int'(done), 1);
        chk(int'(best_score) == bs, req, int'(best_score), bs);
        chk(int'(best_idx) == bi, req, int'(best_idx), bi);
        @(negedge clk);
        chk(done == 1'b0, "R8 done single cycle", int'(done), 0);
    endtask

    task automatic grid(input string req);
        for (int h = 0; h <= EMAX; h += 9) begin
            for (int v = 0; v <= EMAX; v += 9) begin
                h_arr[0] = h;
                v_arr[0] = v;
                run_sweep(1, req);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset values, R10: ready high
        chk(done == 1'b0, "R11 done", int'(done), 0);
        chk(config_error == 1'b0, "R11 config_error", int'(config_error), 0);
        chk(best_idx == '0, "R11 best_idx", int'(best_idx), 0);
        chk(best_score == '0, "R11 best_score", int'(best_score), 0);
        chk(in_ready == 1'b1, "R10 ready", int'(in_ready), 1);
        rst = 1'b0;

        ctle_mode = 2'd1; grid("R1 HEO mode");
        ctle_mode = 2'd2; grid("R2 VEO mode");
        ctle_mode = 2'd3; veo_scale = 8'd64;  grid("R3 min mode unity");
        veo_scale = 8'd200; grid("R3 min mode saturating scale");
        veo_scale = 8'd17;  grid("R3 min mode small scale");

        ctle_cfg_en = 1'b1;
        fac_a = 8'd128; ofs_b = 8'd10;  ofs_c = 8'd20; grid("R5 weighted half");
        fac_a = 8'd0;   ofs_b = 8'd0;   ofs_c = 8'd63; grid("R5 weighted a=0");
        fac_a = 8'd255; ofs_b = 8'd255; ofs_c = 8'd0;  grid("R5 weighted negative");

        // R6: decision-feedback set selected; continuous-time set ignored
        sweep_sel = 1'b1; dfe_mode = 2'd2; dfe_cfg_en = 1'b0;
        ctle_cfg_en = 1'b1; ctle_mode = 2'd1;
        h_arr[0] = 10; v_arr[0] = 50; run_sweep(1, "R6 dfe set used");
        dfe_cfg_en = 1'b1; fac_a = 8'd64; ofs_b = 8'd5; ofs_c = 8'd7;
        h_arr[0] = 40; v_arr[0] = 12; run_sweep(1, "R6 shared factors dfe");
        sweep_sel = 1'b0; ctle_cfg_en = 1'b0; ctle_mode = 2'd1; dfe_mode = 2'd2;
        run_sweep(1, "R6 ctle set used");

        // R7/R10: multi-candidate back-to-back sweeps over rotating configurations
        for (int s = 0; s < 24; s++) begin
            sweep_sel   = s[0];
            ctle_mode   = 2'((s % 3) + 1);
            dfe_mode    = 2'(((s + 1) % 3) + 1);
            ctle_cfg_en = (s % 5) == 4;
            dfe_cfg_en  = (s % 7) == 6;
            fac_a = 8'(rnd() * 4); ofs_b = 8'(rnd()); ofs_c = 8'(rnd());
            veo_scale = 8'(rnd() * 3 + 8);
            for (int i = 0; i < 16; i++) begin
                h_arr[i] = rnd();
                v_arr[i] = rnd();
            end
            run_sweep(16, "R7 R10 best of sweep");
        end

        // R7: ties keep the earliest candidate
        sweep_sel = 1'b0; ctle_cfg_en = 1'b0; ctle_mode = 2'd1;
        for (int i = 0; i < 8; i++) begin h_arr[i] = 30; v_arr[i] = i; end
        run_sweep(8, "R7 all equal");
        h_arr[0] = 5; h_arr[1] = 40; h_arr[2] = 12; h_arr[3] = 40;
        run_sweep(4, "R7 later tie");

        // R9: a low sweep after a high sweep reports its own best
        for (int i = 0; i < 4; i++) h_arr[i] = 60 + i;
        run_sweep(4, "R9 high sweep");
        h_arr[0] = 3; h_arr[1] = 7; h_arr[2] = 2;
        run_sweep(3, "R9 low sweep after start");

        // R4: code 0 with formula enabled leaves the flag clear
        ctle_mode = 2'd0; ctle_cfg_en = 1'b1; fac_a = 8'd100; ofs_b = 8'd3; ofs_c = 8'd9;
        h_arr[0] = 20; v_arr[0] = 33; run_sweep(1, "R4 code0 with formula");
        chk(config_error == 1'b0, "R4 no error with formula", int'(config_error), 0);
        // R4: code 0 without formula behaves as min mode and sets the flag
        ctle_cfg_en = 1'b0; veo_scale = 8'd32;
        h_arr[0] = 50; v_arr[0] = 40; run_sweep(1, "R4 code0 fallback");
        chk(config_error == 1'b1, "R4 error set", int'(config_error), 1);
        ctle_mode = 2'd1;
        run_sweep(1, "R4 later sweep");
        chk(config_error == 1'b1, "R4 error sticky", int'(config_error), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule